// File: doc/BRIEF.md
# Multi-Format Video Pixel Input Capture

This block is the pixel input port of a video encoder. On every rising edge of a double-rate capture clock it takes one pixel from a parallel bus, along with overlay select bits, mode bits and the blanking and sync strobes. It delivers one pixel per clock as three full 8-bit channels. Overlay, mode and timing travel alongside the pixel and stay aligned with it.

The bus carries one of three formats. The first is 16-bit luma/chroma 4:2:2, with luma on bits 15:8 and a shared chroma byte on bits 7:0 that alternates blue-difference then red-difference. The second is 16-bit 5-6-5 RGB. The third is 24-bit RGB. In the 4:2:2 format, consecutive even/odd pixel pairs are given one common chroma pair. Each output pixel therefore carries its own luma plus both chroma samples.

The block also produces a companion clock at half the capture rate, which can be switched on or off.

Top module: `vid_pix_capture`

## Requirements
- R1: A sample present at capture edge n appears on all outputs just after edge n+2, in every format. The pixel, overlay, mode, blank, hsync and vsync outputs therefore stay aligned with one another.
- R2: Format code 0 selects 4:2:2, with luma taken from pix_in[15:8] and chroma from pix_in[7:0]. The output is {luma, Cb, Cr} on bits [23:16], [15:8] and [7:0]. An even pixel outputs its own chroma byte as Cb and the next pixel's chroma byte as Cr. An odd pixel outputs the previous pixel's chroma byte as Cb and its own chroma byte as Cr.
- R3: The chroma phase restarts at Cb (even) on the first active pixel after blank_in has been high, whatever the length of the previous line. An even pixel with no active successor outputs Cr = 0x80.
- R4: Format code 1 decodes pix_in[15:0] as R = bits 15:11, G = bits 10:5 and B = bits 4:0. Each channel is widened to 8 bits by repeating its most significant bits below it. pix_in[23:16] is ignored in this format.
- R5: Format code 2 passes pix_in[23:0] through unchanged. Code 3 behaves the same as code 2.
- R6: The format code is loaded only on edges where blank_in is high. A code presented while blank_in is low has no effect on the pixels that follow.
- R7: valid_out is the inverse of the delayed blank. While blank_out is high, pix_out is zero.
- R8: While half_en is high, clk_half inverts on every capture edge. On an edge where half_en is low, clk_half goes low.
- R9: While rst_n is low, the block immediately forces pix_out, ovl_out and mode_out to zero, blank_out high, hs_out, vs_out and valid_out low, and clk_half low. Reset release takes effect synchronously.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk2 | input | 1 | Double-rate capture clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_sel | input | 2 | Format code: 0 = 4:2:2, 1 = RGB 5-6-5, 2/3 = RGB 24-bit |
| pix_in | input | 24 | Parallel pixel bus |
| ovl_in | input | 3 | Overlay select bits |
| mode_in | input | 2 | Mode bits |
| blank_in | input | 1 | Blanking strobe, high = no active pixel |
| hs_in | input | 1 | Horizontal sync |
| vs_in | input | 1 | Vertical sync |
| half_en | input | 1 | Enable for the half-rate clock output |
| pix_out | output | 24 | Pixel as {R/Y, G/Cb, B/Cr} |
| ovl_out | output | 3 | Overlay bits aligned to pix_out |
| mode_out | output | 2 | Mode bits aligned to pix_out |
| blank_out | output | 1 | Delayed blank |
| hs_out | output | 1 | Delayed horizontal sync |
| vs_out | output | 1 | Delayed vertical sync |
| valid_out | output | 1 | High for an active pixel |
| clk_half | output | 1 | Half-rate companion clock |

## Verification
The bench builds the block with its default parameters: 8-bit channels, 3 overlay bits and 2 mode bits. With those values the 5-6-5 widening and the neutral 0x80 chroma can be written as exact byte patterns. One stimulus table runs through every format code. It includes lines of odd length in 4:2:2, and format codes offered in mid-line that must not take effect. This makes chroma re-phasing and format latching observable at the pixel output.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
  localparam int FMT_W = 2;

  typedef enum logic [FMT_W-1:0] {
    FMT_YC16  = 2'd0,
    FMT_RGB16 = 2'd1,
    FMT_RGB24 = 2'd2,
    FMT_ALT24 = 2'd3
  } fmt_e;
endpackage

// File: rtl/vpc_rst_sync.sv
module vpc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/vpc_capture.sv
module vpc_capture
  import vpc_pkg::*;
#(
  parameter int CH_W   = 8,
  parameter int OVL_W  = 3,
  parameter int MODE_W = 2,
  localparam int PIX_W = 3 * CH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FMT_W-1:0]  fmt_sel,
  input  logic [PIX_W-1:0]  pix_in,
  input  logic [OVL_W-1:0]  ovl_in,
  input  logic [MODE_W-1:0] mode_in,
  input  logic              blank_in,
  input  logic              hs_in,
  input  logic              vs_in,
  output logic [PIX_W-1:0]  s1_pix,
  output logic [OVL_W-1:0]  s1_ovl,
  output logic [MODE_W-1:0] s1_mode,
  output logic              s1_blank,
  output logic              s1_hs,
  output logic              s1_vs,
  output logic              s1_odd,
  output fmt_e              s1_fmt
);
  fmt_e fmt_q, fmt_d;
  logic fmt_en;
  logic ph_q, ph_d;
  logic s1_odd_d;

  // Format latches only during blanking; phase restarts at even on blank.
  always_comb begin
    fmt_en   = blank_in;
    fmt_d    = fmt_e'(fmt_sel);
    s1_odd_d = !blank_in && ph_q;
    ph_d     = !blank_in && !ph_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q <= FMT_YC16;
    end else if (fmt_en) begin
      fmt_q <= fmt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= 1'b0;
      s1_pix   <= '0;
      s1_ovl   <= '0;
      s1_mode  <= '0;
      s1_blank <= 1'b1;
      s1_hs    <= 1'b0;
      s1_vs    <= 1'b0;
      s1_odd   <= 1'b0;
      s1_fmt   <= FMT_YC16;
    end else begin
      ph_q     <= ph_d;
      s1_pix   <= pix_in;
      s1_ovl   <= ovl_in;
      s1_mode  <= mode_in;
      s1_blank <= blank_in;
      s1_hs    <= hs_in;
      s1_vs    <= vs_in;
      s1_odd   <= s1_odd_d;
      s1_fmt   <= fmt_q;
    end
  end
endmodule

// File: rtl/vpc_pair.sv
module vpc_pair
  import vpc_pkg::*;
#(
  parameter int CH_W   = 8,
  parameter int OVL_W  = 3,
  parameter int MODE_W = 2,
  localparam int PIX_W = 3 * CH_W,
  localparam int R_W   = 5,
  localparam int G_W   = 6,
  localparam int B_W   = 5,
  localparam int B_LO  = 0,
  localparam int G_LO  = B_W,
  localparam int R_LO  = B_W + G_W,
  localparam logic [CH_W-1:0] NEUTRAL = CH_W'(1) << (CH_W - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIX_W-1:0]  s1_pix,
  input  logic [OVL_W-1:0]  s1_ovl,
  input  logic [MODE_W-1:0] s1_mode,
  input  logic              s1_blank,
  input  logic              s1_hs,
  input  logic              s1_vs,
  input  logic              s1_odd,
  input  fmt_e              s1_fmt,
  output logic [PIX_W-1:0]  out_pix,
  output logic [OVL_W-1:0]  out_ovl,
  output logic [MODE_W-1:0] out_mode,
  output logic              out_blank,
  output logic              out_hs,
  output logic              out_vs,
  output logic              out_valid
);
  logic [PIX_W-1:0]  s2_pix;
  logic [OVL_W-1:0]  s2_ovl;
  logic [MODE_W-1:0] s2_mode;
  logic              s2_blank, s2_hs, s2_vs, s2_odd;
  fmt_e              s2_fmt;
  logic [CH_W-1:0]   prev_c;
  logic [PIX_W-1:0]  pix_d;
  logic [CH_W-1:0]   luma, own_c, cb, cr;

  function automatic logic [CH_W-1:0] widen(input logic [5:0] v, input int n);
    logic [CH_W-1:0] r;
    for (int i = 0; i < CH_W; i++) r[CH_W-1-i] = v[n-1-(i%n)];
    return r;
  endfunction

  always_comb begin
    luma  = s2_pix[2*CH_W-1:CH_W];
    own_c = s2_pix[CH_W-1:0];
    if (s2_odd) begin
      cb = prev_c;
      cr = own_c;
    end else begin
      cb = own_c;
      cr = s1_odd ? s1_pix[CH_W-1:0] : NEUTRAL;
    end
    case (s2_fmt)
      FMT_YC16:  pix_d = {luma, cb, cr};
      FMT_RGB16: pix_d = {widen(6'(s2_pix[R_LO +: R_W]), R_W),
                          widen(6'(s2_pix[G_LO +: G_W]), G_W),
                          widen(6'(s2_pix[B_LO +: B_W]), B_W)};
      default:   pix_d = s2_pix;
    endcase
    if (s2_blank) pix_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_pix   <= '0;
      s2_ovl   <= '0;
      s2_mode  <= '0;
      s2_blank <= 1'b1;
      s2_hs    <= 1'b0;
      s2_vs    <= 1'b0;
      s2_odd   <= 1'b0;
      s2_fmt   <= FMT_YC16;
      prev_c   <= '0;
    end else begin
      s2_pix   <= s1_pix;
      s2_ovl   <= s1_ovl;
      s2_mode  <= s1_mode;
      s2_blank <= s1_blank;
      s2_hs    <= s1_hs;
      s2_vs    <= s1_vs;
      s2_odd   <= s1_odd;
      s2_fmt   <= s1_fmt;
      prev_c   <= own_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_pix   <= '0;
      out_ovl   <= '0;
      out_mode  <= '0;
      out_blank <= 1'b1;
      out_hs    <= 1'b0;
      out_vs    <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      out_pix   <= pix_d;
      out_ovl   <= s2_ovl;
      out_mode  <= s2_mode;
      out_blank <= s2_blank;
      out_hs    <= s2_hs;
      out_vs    <= s2_vs;
      out_valid <= !s2_blank;
    end
  end
endmodule

// File: rtl/vpc_half_clk.sv
module vpc_half_clk (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic clk_half
);
  logic half_d;

  always_comb begin
    half_d = en ? !clk_half : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_half <= 1'b0;
    else        clk_half <= half_d;
  end
endmodule

// File: rtl/vid_pix_capture.sv
module vid_pix_capture
  import vpc_pkg::*;
#(
  parameter int CH_W   = 8,
  parameter int OVL_W  = 3,
  parameter int MODE_W = 2,
  localparam int PIX_W = 3 * CH_W
) (
  input  logic              clk2,
  input  logic              rst_n,
  input  logic [FMT_W-1:0]  fmt_sel,
  input  logic [PIX_W-1:0]  pix_in,
  input  logic [OVL_W-1:0]  ovl_in,
  input  logic [MODE_W-1:0] mode_in,
  input  logic              blank_in,
  input  logic              hs_in,
  input  logic              vs_in,
  input  logic              half_en,
  output logic [PIX_W-1:0]  pix_out,
  output logic [OVL_W-1:0]  ovl_out,
  output logic [MODE_W-1:0] mode_out,
  output logic              blank_out,
  output logic              hs_out,
  output logic              vs_out,
  output logic              valid_out,
  output logic              clk_half
);
  logic              rst_s_n;
  logic [PIX_W-1:0]  s1_pix;
  logic [OVL_W-1:0]  s1_ovl;
  logic [MODE_W-1:0] s1_mode;
  logic              s1_blank, s1_hs, s1_vs, s1_odd;
  fmt_e              s1_fmt;

  vpc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk2), .rst_n_in(rst_n), .rst_n_out(rst_s_n)
  );

  vpc_capture #(.CH_W(CH_W), .OVL_W(OVL_W), .MODE_W(MODE_W)) u_cap (
    .clk(clk2), .rst_n(rst_s_n), .fmt_sel(fmt_sel), .pix_in(pix_in),
    .ovl_in(ovl_in), .mode_in(mode_in), .blank_in(blank_in),
    .hs_in(hs_in), .vs_in(vs_in), .s1_pix(s1_pix), .s1_ovl(s1_ovl),
    .s1_mode(s1_mode), .s1_blank(s1_blank), .s1_hs(s1_hs),
    .s1_vs(s1_vs), .s1_odd(s1_odd), .s1_fmt(s1_fmt)
  );

  vpc_pair #(.CH_W(CH_W), .OVL_W(OVL_W), .MODE_W(MODE_W)) u_pair (
    .clk(clk2), .rst_n(rst_s_n), .s1_pix(s1_pix), .s1_ovl(s1_ovl),
    .s1_mode(s1_mode), .s1_blank(s1_blank), .s1_hs(s1_hs),
    .s1_vs(s1_vs), .s1_odd(s1_odd), .s1_fmt(s1_fmt),
    .out_pix(pix_out), .out_ovl(ovl_out), .out_mode(mode_out),
    .out_blank(blank_out), .out_hs(hs_out), .out_vs(vs_out),
    .out_valid(valid_out)
  );

  vpc_half_clk u_half (
    .clk(clk2), .rst_n(rst_s_n), .en(half_en), .clk_half(clk_half)
  );
endmodule

// File: rtl/vpc_checker.sv
module vpc_checker #(
  parameter int OVL_W  = 3,
  parameter int MODE_W = 2,
  parameter int PIX_W  = 24
) (
  input logic              clk,
  input logic              rst_s_n,
  input logic              blank_in,
  input logic              hs_in,
  input logic              vs_in,
  input logic [OVL_W-1:0]  ovl_in,
  input logic [MODE_W-1:0] mode_in,
  input logic              half_en,
  input logic [PIX_W-1:0]  pix_out,
  input logic [OVL_W-1:0]  ovl_out,
  input logic [MODE_W-1:0] mode_out,
  input logic              blank_out,
  input logic              hs_out,
  input logic              vs_out,
  input logic              valid_out,
  input logic              clk_half,
  input logic [1:0]        fmt_q
);
  logic [1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)            run_cnt <= 2'd0;
    else if (run_cnt != 2'd3) run_cnt <= run_cnt + 2'd1;
  end

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_s_n)
    (run_cnt == 2'd3) |-> (valid_out == !$past(blank_in, 3)) &&
      (hs_out == $past(hs_in, 3)) && (vs_out == $past(vs_in, 3)) &&
      (ovl_out == $past(ovl_in, 3)) && (mode_out == $past(mode_in, 3)));

  assert_fmt_hold_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (run_cnt != 2'd0) && !$past(blank_in) |-> $stable(fmt_q));

  assert_blank_zero_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    blank_out |-> (pix_out == '0) && !valid_out);

  assert_half_toggle_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (run_cnt != 2'd0) && $past(half_en) |-> (clk_half != $past(clk_half)));

  assert_half_low_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (run_cnt != 2'd0) && !$past(half_en) |-> !clk_half);
endmodule

bind vid_pix_capture vpc_checker #(.OVL_W(OVL_W), .MODE_W(MODE_W), .PIX_W(PIX_W)) u_chk (
  .clk(clk2), .rst_s_n(rst_s_n), .blank_in(blank_in), .hs_in(hs_in),
  .vs_in(vs_in), .ovl_in(ovl_in), .mode_in(mode_in), .half_en(half_en),
  .pix_out(pix_out), .ovl_out(ovl_out), .mode_out(mode_out),
  .blank_out(blank_out), .hs_out(hs_out), .vs_out(vs_out),
  .valid_out(valid_out), .clk_half(clk_half), .fmt_q(u_cap.fmt_q)
);

// File: tb/vid_pix_capture_test.sv
module vid_pix_capture_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 24;

  typedef struct packed {
    logic        blank;
    logic        hs;
    logic        vs;
    logic [1:0]  fmt;
    logic [2:0]  ovl;
    logic [1:0]  mode;
    logic [23:0] pix;
    logic [23:0] exp;
    logic [3:0]  req;
  } vec_t;

  // blank hs vs fmt ovl mode pix exp req
  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b0,1'b0,2'd0,3'd0,2'd0,24'h000000,24'h000000,4'd7}, // R7 blank
    '{1'b0,1'b0,1'b0,2'd0,3'd1,2'd1,24'h0010A0,24'h10A0B0,4'd2}, // R2 even
    '{1'b0,1'b0,1'b0,2'd0,3'd2,2'd2,24'h0020B0,24'h20A0B0,4'd2}, // R2 odd
    '{1'b0,1'b0,1'b0,2'd0,3'd3,2'd3,24'h0030C0,24'h30C0D0,4'd2},
    '{1'b0,1'b0,1'b0,2'd0,3'd4,2'd0,24'h0040D0,24'h40C0D0,4'd2},
    '{1'b0,1'b0,1'b0,2'd0,3'd5,2'd1,24'h0050E0,24'h50E080,4'd3}, // R3 last even
    '{1'b1,1'b1,1'b0,2'd1,3'd6,2'd2,24'hFFFFFF,24'h000000,4'd7}, // R7 zeroed
    '{1'b1,1'b0,1'b1,2'd1,3'd7,2'd3,24'h000000,24'h000000,4'd6},
    '{1'b0,1'b0,1'b0,2'd2,3'd0,2'd0,24'h00F800,24'hFF0000,4'd4}, // R4, R6 code ignored
    '{1'b0,1'b0,1'b0,2'd2,3'd1,2'd1,24'h0007E0,24'h00FF00,4'd4},
    '{1'b0,1'b0,1'b0,2'd0,3'd2,2'd2,24'h00001F,24'h0000FF,4'd4},
    '{1'b0,1'b0,1'b0,2'd0,3'd3,2'd3,24'h12A5A5,24'hA5B629,4'd4},
    '{1'b1,1'b0,1'b0,2'd2,3'd0,2'd0,24'h000000,24'h000000,4'd6}, // R6 load
    '{1'b0,1'b0,1'b0,2'd0,3'd1,2'd2,24'h123456,24'h123456,4'd5}, // R5
    '{1'b0,1'b1,1'b1,2'd1,3'd2,2'd1,24'hABCDEF,24'hABCDEF,4'd1}, // R1 sync aligned
    '{1'b1,1'b0,1'b0,2'd3,3'd0,2'd0,24'h000000,24'h000000,4'd6},
    '{1'b0,1'b0,1'b0,2'd0,3'd5,2'd3,24'h0F1E2D,24'h0F1E2D,4'd5}, // R5 code 3
    '{1'b1,1'b0,1'b0,2'd0,3'd0,2'd0,24'h000000,24'h000000,4'd6},
    '{1'b0,1'b0,1'b0,2'd0,3'd1,2'd0,24'h006111,24'h611180,4'd3}, // R3 one-pixel line
    '{1'b1,1'b0,1'b0,2'd0,3'd0,2'd0,24'h000000,24'h000000,4'd3},
    '{1'b0,1'b0,1'b0,2'd0,3'd2,2'd1,24'h007122,24'h712233,4'd3}, // R3 restart even
    '{1'b0,1'b0,1'b0,2'd0,3'd3,2'd2,24'h007233,24'h722233,4'd2},
    '{1'b1,1'b0,1'b0,2'd0,3'd0,2'd0,24'h000000,24'h000000,4'd7},
    '{1'b1,1'b0,1'b0,2'd0,3'd0,2'd0,24'h000000,24'h000000,4'd7}
  };

  logic        clk2 = 1'b0;
  logic        rst_n;
  logic [1:0]  fmt_sel;
  logic [23:0] pix_in;
  logic [2:0]  ovl_in;
  logic [1:0]  mode_in;
  logic        blank_in, hs_in, vs_in, half_en;
  logic [23:0] pix_out;
  logic [2:0]  ovl_out;
  logic [1:0]  mode_out;
  logic        blank_out, hs_out, vs_out, valid_out, clk_half;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  vid_pix_capture uut (
    .clk2(clk2), .rst_n(rst_n), .fmt_sel(fmt_sel), .pix_in(pix_in),
    .ovl_in(ovl_in), .mode_in(mode_in), .blank_in(blank_in),
    .hs_in(hs_in), .vs_in(vs_in), .half_en(half_en),
    .pix_out(pix_out), .ovl_out(ovl_out), .mode_out(mode_out),
    .blank_out(blank_out), .hs_out(hs_out), .vs_out(vs_out),
    .valid_out(valid_out), .clk_half(clk_half)
  );

  always #(CLK_PERIOD/2) clk2 = !clk2;

  task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [39:0] snap();
    return {7'd0, pix_out, ovl_out, mode_out, blank_out, hs_out, vs_out, valid_out};
  endfunction

  function automatic logic [39:0] reset_pat();
    return {7'd0, 24'h0, 3'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0};
  endfunction

  task automatic idle();
    blank_in = 1'b1; hs_in = 1'b0; vs_in = 1'b0;
    fmt_sel = 2'd0; pix_in = '0; ovl_in = '0; mode_in = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; half_en = 1'b0;
    idle();
    repeat (3) @(posedge clk2);
    #1;
    // R9 reset state
    check("R9 reset outputs", snap(), reset_pat());
    check("R9 reset clk_half", {39'd0, clk_half}, 40'd0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk2);
    #1;

    // Table walk: output of row k-2 visible after the edge capturing row k (R1)
    for (int k = 0; k < NV + 2; k++) begin
      if (k < NV) begin
        blank_in = TBL[k].blank; hs_in = TBL[k].hs; vs_in = TBL[k].vs;
        fmt_sel = TBL[k].fmt; ovl_in = TBL[k].ovl; mode_in = TBL[k].mode;
        pix_in = TBL[k].pix;
      end else begin
        idle();
      end
      @(posedge clk2);
      #1;
      if (k >= 2) begin
        vec_t e;
        e = TBL[k-2];
        check($sformatf("R%0d row %0d", e.req, k-2), snap(),
              {7'd0, e.exp, e.ovl, e.mode, e.blank, e.hs, e.vs, !e.blank});
      end
    end

    // R8 half-rate clock
    begin
      logic a, b;
      half_en = 1'b1;
      @(posedge clk2); #1; a = clk_half;
      @(posedge clk2); #1; b = clk_half;
      check("R8 toggle 1", {39'd0, b}, {39'd0, !a});
      @(posedge clk2); #1;
      check("R8 toggle 2", {39'd0, clk_half}, {39'd0, !b});
      half_en = 1'b0;
      @(posedge clk2); #1;
      check("R8 low when disabled", {39'd0, clk_half}, 40'd0);
      @(posedge clk2); #1;
      check("R8 stays low", {39'd0, clk_half}, 40'd0);
    end

    // R9 asynchronous reset during an active line
    half_en = 1'b1;
    fmt_sel = 2'd2; blank_in = 1'b1;
    @(posedge clk2); #1;
    blank_in = 1'b0; pix_in = 24'h5A5A5A; ovl_in = 3'd7; mode_in = 2'd3; hs_in = 1'b1;
    repeat (3) @(posedge clk2);
    #1;
    check("R9 pre-reset active", {39'd0, valid_out}, {39'd0, 1'b1});
    rst_n = 1'b0;
    #1;
    check("R9 async reset outputs", snap(), reset_pat());
    check("R9 async reset clk_half", {39'd0, clk_half}, 40'd0);

    finish_run();
  end
endmodule